// File: doc/BRIEF.md
# Packed Audio FIFO Unpacker

This block sits between a sample FIFO and a digital audio transmitter. The FIFO holds 64-bit entries, and each entry carries several audio samples packed side by side. A run-time packing code chooses one of three layouts: eight 8-bit containers, four 16-bit containers or two 32-bit containers per entry. Within its container each sample is right-justified. A 5-bit field gives the index of the sample MSB inside the container, so 8-, 16-, 20- and 24-bit audio can all be carried.

The transmitter asks for one frame at a time with `frame_req`. The block answers with a left/right pair, each sample moved so that its MSB is at bit 23 of a 24-bit output. The low two bits of an 8-bit channel mask choose between stereo (two containers per frame), mono (one container copied to both outputs) and silence (no container used). If the FIFO is empty when a container is due, the block outputs zeros and raises an underflow flag with that frame.

Top module: `packed_fifo_unpacker`

## Requirements
- R1: After reset `out_valid`, `out_underflow` and `fifo_pop` are low, and `out_left` and `out_right` are zero.
- R2: Packing code 0 gives eight 8-bit containers per entry, code 2 gives four 16-bit containers and code 4 gives two 32-bit containers. Container k occupies entry bits [k*W+W-1 : k*W] and containers are used in rising order of k, starting from k = 0.
- R3: The FIFO is first-word-fall-through. `fifo_pop` pulses only in the cycle that uses the last container of the head entry, and never while `fifo_empty` is high.
- R4: Container bits above the MSB index are ignored. Container bit `msb` appears at output bit 23 and lower bits follow in order, with zero fill below them. When `msb` is above 23, the container bits below `msb-23` are dropped.
- R5: With mask bits [1:0] = 11 (stereo), the first container goes to `out_left` and the next container goes to `out_right`. `out_valid` is a one-cycle pulse, high after the second clock edge that follows the edge which sampled `frame_req`.
- R6: With exactly one of mask bits [1:0] set (mono), one container is used per frame and it is driven to both outputs. `out_valid` is high after the first edge that follows the edge which sampled `frame_req`.
- R7: Mask bits [7:2] have no effect. With mask bits [1:0] = 00, a frame uses no container, outputs zeros and does not flag underflow.
- R8: A packing code other than 0, 2 or 4 is unsupported. Such a frame outputs zeros, pops nothing, uses no container and does not flag underflow.
- R9: If a container is due while `fifo_empty` is high, that sample is zero, `out_underflow` is high together with `out_valid`, and the container position does not advance.
- R10: A `frame_req` that arrives while a frame is still being assembled is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_type | input | 3 | Packing code (0, 2 or 4) |
| cfg_msb_pos | input | 5 | Index of the sample MSB inside its container |
| cfg_chan_mask | input | 8 | Channel mask; bits [1:0] select stereo, mono or silence |
| fifo_data | input | 64 | Head entry of the sample FIFO |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_pop | output | 1 | Removes the head entry |
| frame_req | input | 1 | Request for one output frame |
| out_valid | output | 1 | One-cycle pulse: a new pair is on the outputs |
| out_left | output | 24 | Left sample, MSB-aligned |
| out_right | output | 24 | Right sample, MSB-aligned |
| out_underflow | output | 1 | The frame just delivered found the FIFO empty |

## Verification
The assertions check a set of rules on every cycle. A pop never happens against an empty FIFO, never comes from a cycle that uses no container, and never happens under an unsupported packing code. A valid pulse lasts exactly one cycle. Mono frames carry identical channels. Silent and unsupported frames deliver zeros, and the underflow flag appears only with a valid pulse. Other behaviour can only be shown by the directed scenarios: which container feeds which channel, the exact bit alignment for each MSB position, how many frames one entry lasts, the latency, that the position holds through an underflow, and that requests are dropped while a frame is being built.

// File: rtl/pfu_pkg.sv
package pfu_pkg;

  localparam int WORD_W   = 64;
  localparam int CONT_MAX = 32;
  localparam int OUT_W    = 24;
  localparam int MSB_W    = 5;
  localparam int TYPE_W   = 3;
  localparam int SLOT_W   = $clog2(WORD_W / 8);
  localparam int CNT_W    = SLOT_W + 1;

  localparam logic [TYPE_W-1:0] PACK_B8  = 3'd0;
  localparam logic [TYPE_W-1:0] PACK_B16 = 3'd2;
  localparam logic [TYPE_W-1:0] PACK_B32 = 3'd4;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_FIRST,
    SEQ_SECOND
  } seq_state_e;

  // Containers per 64-bit entry; zero marks an unsupported code.
  function automatic logic [CNT_W-1:0] slots_per_word(logic [TYPE_W-1:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      PACK_B8:  n = CNT_W'(WORD_W / 8);
      PACK_B16: n = CNT_W'(WORD_W / 16);
      PACK_B32: n = CNT_W'(WORD_W / 32);
      default:  n = '0;
    endcase
    return n;
  endfunction

  // Drop bits above msb, then place bit msb at the top of the output.
  function automatic logic [OUT_W-1:0] align_msb(logic [CONT_MAX-1:0] cont,
                                                  logic [MSB_W-1:0] msb);
    logic [CONT_MAX-1:0]       kept;
    logic [CONT_MAX+OUT_W-1:0] wide;
    kept = cont & ~(({CONT_MAX{1'b1}} << msb) << 1);
    wide = ({kept, {OUT_W{1'b0}}} >> msb) >> 1;
    return wide[OUT_W-1:0];
  endfunction

endpackage

// File: rtl/pfu_slot_extract.sv
module pfu_slot_extract
  import pfu_pkg::*;
#(
  parameter int WORD_BITS = WORD_W
) (
  input  logic [WORD_BITS-1:0] word,
  input  logic [TYPE_W-1:0]    pack_code,
  input  logic [SLOT_W-1:0]    slot,
  input  logic [MSB_W-1:0]     msb_pos,
  output logic [OUT_W-1:0]     sample
);

  localparam int NUM_PACK = 3;

  logic [CONT_MAX-1:0] cand [NUM_PACK];
  logic [CONT_MAX-1:0] picked;

  // One candidate container per packing width: 8, 16 and 32 bits.
  for (genvar g = 0; g < NUM_PACK; g++) begin : g_pack
    localparam int CW = 8 << g;
    localparam int NC = WORD_BITS / CW;
    localparam logic [SLOT_W-1:0] IDX_MASK = SLOT_W'(NC - 1);
    logic [SLOT_W-1:0] idx;
    assign idx     = slot & IDX_MASK;
    assign cand[g] = CONT_MAX'(word[int'(idx)*CW +: CW]);
  end

  always_comb begin
    case (pack_code)
      PACK_B8:  picked = cand[0];
      PACK_B16: picked = cand[1];
      PACK_B32: picked = cand[2];
      default:  picked = '0;
    endcase
  end

  assign sample = align_msb(picked, msb_pos);

endmodule

// File: rtl/pfu_slot_ctr.sv
module pfu_slot_ctr
  import pfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [CNT_W-1:0]  slots,
  output logic [SLOT_W-1:0] slot,
  output logic              word_done
);

  logic last_slot;

  assign last_slot = (CNT_W'(slot) + CNT_W'(1)) >= slots;
  assign word_done = take && last_slot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot <= '0;
    end else if (take) begin
      slot <= last_slot ? '0 : slot + SLOT_W'(1);
    end
  end

endmodule

// File: rtl/pfu_frame_seq.sv
module pfu_frame_seq
  import pfu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_req,
  input  logic stereo_in,
  output logic fetch,
  output logic fetch_second,
  output logic stereo_q,
  output logic frame_done
);

  seq_state_e state, state_nx;

  assign fetch        = (state != SEQ_IDLE);
  assign fetch_second = (state == SEQ_SECOND);
  assign frame_done   = fetch_second || ((state == SEQ_FIRST) && !stereo_q);

  always_comb begin
    state_nx = state;
    case (state)
      SEQ_IDLE:   if (frame_req) state_nx = SEQ_FIRST;
      SEQ_FIRST:  state_nx = stereo_q ? SEQ_SECOND : SEQ_IDLE;
      SEQ_SECOND: state_nx = SEQ_IDLE;
      default:    state_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      stereo_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (state == SEQ_IDLE && frame_req) stereo_q <= stereo_in;
    end
  end

endmodule

// File: rtl/packed_fifo_unpacker.sv
module packed_fifo_unpacker
  import pfu_pkg::*;
#(
  parameter int MASK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TYPE_W-1:0] cfg_type,
  input  logic [MSB_W-1:0]  cfg_msb_pos,
  input  logic [MASK_W-1:0] cfg_chan_mask,
  input  logic [WORD_W-1:0] fifo_data,
  input  logic              fifo_empty,
  output logic              fifo_pop,
  input  logic              frame_req,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_left,
  output logic [OUT_W-1:0]  out_right,
  output logic              out_underflow
);

  logic [1:0]        chan_sel;
  logic              any_chan, stereo_now;
  logic [CNT_W-1:0]  slots;
  logic              type_ok;
  logic              fetch_evt, fetch_second, stereo_q, frame_done;
  logic              want, take, starve, word_done;
  logic [SLOT_W-1:0] slot;
  logic [OUT_W-1:0]  extracted, sample_now;
  logic              uf_acc, uf_now;
  logic              unused_mask_hi;

  assign chan_sel       = cfg_chan_mask[1:0];
  assign unused_mask_hi = |cfg_chan_mask[MASK_W-1:2];
  assign any_chan       = |chan_sel;
  assign stereo_now     = &chan_sel;
  assign slots          = slots_per_word(cfg_type);
  assign type_ok        = (slots != '0);

  pfu_frame_seq i_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_req    (frame_req),
    .stereo_in    (stereo_now),
    .fetch        (fetch_evt),
    .fetch_second (fetch_second),
    .stereo_q     (stereo_q),
    .frame_done   (frame_done)
  );

  assign want   = fetch_evt && type_ok && any_chan;
  assign take   = want && !fifo_empty;
  assign starve = want && fifo_empty;

  pfu_slot_ctr i_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .slots     (slots),
    .slot      (slot),
    .word_done (word_done)
  );

  pfu_slot_extract #(.WORD_BITS(WORD_W)) i_ext (
    .word      (fifo_data),
    .pack_code (cfg_type),
    .slot      (slot),
    .msb_pos   (cfg_msb_pos),
    .sample    (extracted)
  );

  assign fifo_pop   = word_done;
  assign sample_now = take ? extracted : '0;
  assign uf_now     = starve || (fetch_second && uf_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_underflow <= 1'b0;
      out_left      <= '0;
      out_right     <= '0;
      uf_acc        <= 1'b0;
    end else begin
      out_valid     <= frame_done;
      out_underflow <= frame_done && uf_now;
      if (fetch_evt && !fetch_second) begin
        out_left <= sample_now;
        uf_acc   <= starve;
      end
      if (fetch_evt && (fetch_second || !stereo_q)) begin
        out_right <= sample_now;
      end
    end
  end

endmodule

// File: rtl/pfu_checker.sv
module pfu_checker
  import pfu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [TYPE_W-1:0] cfg_type,
  input logic [7:0]        cfg_chan_mask,
  input logic              fifo_empty,
  input logic              fifo_pop,
  input logic              out_valid,
  input logic              out_underflow,
  input logic [OUT_W-1:0]  out_left,
  input logic [OUT_W-1:0]  out_right,
  input logic              take,
  input logic              fetch_evt
);

  logic mono_cfg, bad_type;
  assign mono_cfg = (cfg_chan_mask[1:0] == 2'b01) || (cfg_chan_mask[1:0] == 2'b10);
  assign bad_type = (slots_per_word(cfg_type) == '0);

  p_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);

  p_pop_needs_use_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (take && fetch_evt));

  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_mono_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && mono_cfg) |-> (out_left == out_right));

  p_silent_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_chan_mask[1:0] == 2'b00) |->
      (out_left == '0 && out_right == '0 && !out_underflow));

  p_bad_type_nopop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_type |-> !fifo_pop);

  p_bad_type_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && bad_type) |-> (out_left == '0 && out_right == '0 && !out_underflow));

  p_uf_with_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_underflow |-> out_valid);

endmodule

bind packed_fifo_unpacker pfu_checker i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_type      (cfg_type),
  .cfg_chan_mask (cfg_chan_mask),
  .fifo_empty    (fifo_empty),
  .fifo_pop      (fifo_pop),
  .out_valid     (out_valid),
  .out_underflow (out_underflow),
  .out_left      (out_left),
  .out_right     (out_right),
  .take          (take),
  .fetch_evt     (fetch_evt)
);

// File: tb/test_packed_fifo_unpacker.sv
`timescale 1ns/1ps
module test_packed_fifo_unpacker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_type = 3'd4;
  logic [4:0]  cfg_msb_pos = 5'd23;
  logic [7:0]  cfg_chan_mask = 8'h03;
  logic [63:0] fifo_data;
  logic        fifo_empty;
  logic        fifo_pop;
  logic        frame_req = 1'b0;
  logic        out_valid;
  logic [23:0] out_left, out_right;
  logic        out_underflow;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #2.5 clk = ~clk;

  // Bench FIFO model: first-word-fall-through, 16 entries.
  logic [63:0] mem [16];
  logic [3:0]  rd = '0, wr = '0;
  int          pops = 0;
  assign fifo_data  = mem[rd];
  assign fifo_empty = (rd == wr);
  always @(posedge clk) if (rst_n && fifo_pop) begin rd <= rd + 4'd1; pops <= pops + 1; end

  packed_fifo_unpacker i_packed_fifo_unpacker (
    .clk, .rst_n, .cfg_type, .cfg_msb_pos, .cfg_chan_mask,
    .fifo_data, .fifo_empty, .fifo_pop, .frame_req,
    .out_valid, .out_left, .out_right, .out_underflow
  );

  function automatic logic [23:0] ref_sample(logic [63:0] w, int code, int k, int msb);
    int wd;
    logic [23:0] r;
    wd = (code == 0) ? 8 : (code == 2) ? 16 : 32;
    r = '0;
    for (int i = 0; i < 24; i++) begin
      int src;
      src = msb - 23 + i;
      if (src >= 0 && src < wd) r[i] = w[k*wd + src];
    end
    return r;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic push(logic [63:0] w);
    @(negedge clk);
    mem[wr] = w;
    wr = wr + 4'd1;
  endtask

  task automatic set_cfg(int code, int msb, logic [7:0] mask);
    @(negedge clk);
    cfg_type = 3'(code); cfg_msb_pos = 5'(msb); cfg_chan_mask = mask;
  endtask

  task automatic frame(output logic [23:0] l, output logic [23:0] r, output logic uf, output int lat);
    @(negedge clk); frame_req = 1'b1;
    @(negedge clk); frame_req = 1'b0; lat = 1;
    while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
    l = out_left; r = out_right; uf = out_underflow;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "valid", 64'(out_valid), 0);
    chk("R1", "underflow", 64'(out_underflow), 0);
    chk("R1", "left", 64'(out_left), 0);
    chk("R1", "right", 64'(out_right), 0);
    chk("R1", "pop", 64'(fifo_pop), 0);
  endtask

  task automatic t_stereo32();
    logic [23:0] l, r; logic uf; int lat, p0;
    logic [63:0] w = 64'hC3A5_1234_7E65_4321;
    set_cfg(4, 23, 8'h03); push(w); p0 = pops;
    frame(l, r, uf, lat);
    chk("R2", "stereo32 left slot0", 64'(l), 64'(ref_sample(w, 4, 0, 23)));
    chk("R2", "stereo32 right slot1", 64'(r), 64'(ref_sample(w, 4, 1, 23)));
    chk("R5", "stereo latency", 64'(lat), 3);
    chk("R3", "stereo32 one pop", 64'(pops - p0), 1);
  endtask

  task automatic t_stereo16();
    logic [23:0] l, r; logic uf; int lat, p0;
    logic [63:0] w = 64'h8001_7FFE_1234_ABCD;
    set_cfg(2, 15, 8'h03); push(w); p0 = pops;
    frame(l, r, uf, lat);
    chk("R3", "no pop mid-entry", 64'(pops - p0), 0);
    chk("R2", "s16 slot0", 64'(l), 64'(ref_sample(w, 2, 0, 15)));
    chk("R2", "s16 slot1", 64'(r), 64'(ref_sample(w, 2, 1, 15)));
    frame(l, r, uf, lat);
    chk("R3", "pop after last slot", 64'(pops - p0), 1);
    chk("R2", "s16 slot2", 64'(l), 64'(ref_sample(w, 2, 2, 15)));
    chk("R2", "s16 slot3", 64'(r), 64'(ref_sample(w, 2, 3, 15)));
  endtask

  task automatic t_mono8();
    logic [23:0] l, r; logic uf; int lat, p0;
    logic [63:0] w = 64'hF0E1_D2C3_B4A5_9687;
    set_cfg(0, 7, 8'h01); push(w); p0 = pops;
    for (int k = 0; k < 8; k++) begin
      frame(l, r, uf, lat);
      chk("R6", "mono8 left", 64'(l), 64'(ref_sample(w, 0, k, 7)));
      chk("R6", "mono8 right copy", 64'(r), 64'(ref_sample(w, 0, k, 7)));
      if (k == 0) chk("R6", "mono latency", 64'(lat), 2);
      if (k == 6) chk("R3", "mono8 no early pop", 64'(pops - p0), 0);
    end
    chk("R3", "mono8 pop after 8", 64'(pops - p0), 1);
  endtask

  task automatic t_msb_pos();
    logic [23:0] l, r; logic uf; int lat;
    logic [63:0] w = 64'hFFF8_1234_ABC5_6789;
    set_cfg(4, 19, 8'h03); push(w);
    frame(l, r, uf, lat);
    chk("R4", "msb19 junk ignored L", 64'(l), 64'({4'h5, 16'h6789, 4'h0}));
    chk("R4", "msb19 junk ignored R", 64'(r), 64'({4'h8, 16'h1234, 4'h0}));
    set_cfg(4, 31, 8'h03); push(w);
    frame(l, r, uf, lat);
    chk("R4", "msb31 truncation L", 64'(l), 64'(24'hABC567));
    chk("R4", "msb31 truncation R", 64'(r), 64'(24'hFFF812));
  endtask

  task automatic t_mask_hi();
    logic [23:0] l, r; logic uf; int lat, p0;
    logic [63:0] w = 64'h0BAD_F00D_1357_2468;
    set_cfg(2, 15, 8'hFE); push(w); p0 = pops;
    for (int k = 0; k < 4; k++) begin
      frame(l, r, uf, lat);
      chk("R7", "mask hi bits ignored, mono", 64'(l), 64'(ref_sample(w, 2, k, 15)));
      chk("R6", "mono copy via bit1", 64'(r), 64'(l));
    end
    chk("R7", "mask hi pop", 64'(pops - p0), 1);
  endtask

  task automatic t_silent_and_bad();
    logic [23:0] l, r; logic uf; int lat, p0;
    logic [63:0] w = 64'h1111_2222_3333_4444;
    push(w); p0 = pops;
    set_cfg(4, 23, 8'hFC);
    frame(l, r, uf, lat);
    chk("R7", "silent zeros", 64'({l, r}), 0);
    chk("R7", "silent no uf", 64'(uf), 0);
    chk("R7", "silent no pop", 64'(pops - p0), 0);
    set_cfg(3, 23, 8'h03);
    frame(l, r, uf, lat);
    chk("R8", "code3 zeros", 64'({l, r}), 0);
    chk("R8", "code3 no uf", 64'(uf), 0);
    set_cfg(7, 23, 8'h01);
    frame(l, r, uf, lat);
    chk("R8", "code7 zeros", 64'({l, r}), 0);
    chk("R8", "code7 no pop", 64'(pops - p0), 0);
    set_cfg(4, 23, 8'h03);
    frame(l, r, uf, lat);
    chk("R8", "entry untouched L", 64'(l), 64'(ref_sample(w, 4, 0, 23)));
    chk("R7", "entry untouched R", 64'(r), 64'(ref_sample(w, 4, 1, 23)));
  endtask

  task automatic t_underflow();
    logic [23:0] l, r; logic uf; int lat, p0;
    logic [63:0] w = 64'h5555_AAAA_0F0F_F0F0;
    set_cfg(4, 23, 8'h03); p0 = pops;
    chk("R9", "fifo empty before", 64'(fifo_empty), 1);
    frame(l, r, uf, lat);
    chk("R9", "uf flag", 64'(uf), 1);
    chk("R9", "uf zeros", 64'({l, r}), 0);
    chk("R9", "uf no pop", 64'(pops - p0), 0);
    push(w);
    frame(l, r, uf, lat);
    chk("R9", "after uf flag clear", 64'(uf), 0);
    chk("R9", "position held L", 64'(l), 64'(ref_sample(w, 4, 0, 23)));
    chk("R9", "position held R", 64'(r), 64'(ref_sample(w, 4, 1, 23)));
  endtask

  task automatic t_busy_req();
    logic [23:0] l, r; logic uf; int lat, p0, pulses;
    logic [63:0] w = 64'hDEAD_BEEF_CAFE_0123;
    set_cfg(2, 15, 8'h03); push(w); p0 = pops; pulses = 0;
    @(negedge clk); frame_req = 1'b1;
    @(negedge clk);
    @(negedge clk); frame_req = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (out_valid) pulses++;
      @(negedge clk);
    end
    chk("R10", "one frame for held req", 64'(pulses), 1);
    chk("R10", "no pop after one frame", 64'(pops - p0), 0);
    frame(l, r, uf, lat);
    chk("R10", "next frame slot2", 64'(l), 64'(ref_sample(w, 2, 2, 15)));
    chk("R10", "entry popped", 64'(pops - p0), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_stereo32();
    t_stereo16();
    t_mono8();
    t_msb_pos();
    t_mask_hi();
    t_silent_and_bad();
    t_underflow();
    t_busy_req();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule